// File: doc/BRIEF.md
# LIN Response Field Sequencer

This block runs the data part of a LIN frame response once the header has been handled elsewhere. In transmit mode it reads the response bytes from an external byte buffer, hands them one at a time to a byte-level UART serializer over a valid/ready handshake, and then sends the inverted checksum. In receive mode it takes bytes from a UART deserializer, writes each into the byte buffer, adds the final byte into the running checksum and reports a mismatch.

A response longer than eight bytes is sent or received as a chain of data groups. Each group has its own length and continuation setting, and software loads these before the group starts. The running checksum carries across all groups. Only the final group carries the checksum byte. Classic checksum (data only) or enhanced checksum (protected identifier plus data) is chosen per frame.

Configuration is sampled at one of two points. At the header-start pulse, direction, checksum mode and the frame-separate setting are always captured. The length and continuation setting are captured at the same pulse when frame-separate is off. When frame-separate is on, they are instead taken live at the response-start pulse. For every group after the first, they are always taken live at that group's start pulse.

Top module: `lin_resp_seq`

## Requirements
- R1: After reset the block is idle. busy, grp_wait, done, cks_err, cfg_err, tx_valid and buf_we are all 0.
- R2: A response-start pulse whose effective length code is 9 to 15 raises cfg_err for one cycle in the following cycle. The state does not change and no byte is moved.
- R3: In transmit mode (direction bit 1), the block presents buffer bytes 0 to len-1 in order on tx_data, with buf_idx giving the position. Each byte stays on tx_data, with tx_valid high, until the cycle in which tx_ready is 1.
- R4: In receive mode (direction bit 0), the block writes each received data byte through buf_we/buf_wdata at buf_idx 0, 1, 2 and so on. If the checksum byte does not make the running sum 0xFF, cks_err is raised in the same cycle as done.
- R5: In enhanced mode (checksum bit 1), the protected identifier seeds the running sum at the start of a frame's first group. In classic mode (checksum bit 0) the seed is 0.
- R6: Each byte is added into the running sum as an 8-bit sum, with any carry out of bit 7 added back in. The transmitted checksum byte is the bitwise inverse of the final sum.
- R7: A final group of length 0 consists of the checksum byte alone.
- R8: A group whose continuation bit is 1 sends or receives no checksum byte and ends with grp_wait high. The next response-start pulse continues the running sum without seeding it again.
- R9: With frame-separate off, the length and continuation setting are those present at the header-start pulse. With frame-separate on, they are those present at the response-start pulse. Direction and checksum mode are always taken at the header-start pulse.
- R10: A response-start pulse is ignored unless the block is idle or in grp_wait. A header-start pulse is ignored unless the block is idle.
- R11: done is high for exactly one cycle, the cycle after the checksum byte is handed over. The block is idle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_len | input | 4 | Data length of the group, 0 to 8 |
| cfg_more | input | 1 | 1: another group follows and this group has no checksum |
| cfg_enh | input | 1 | 1: enhanced checksum, 0: classic checksum |
| cfg_tx | input | 1 | 1: transmit, 0: receive |
| cfg_sep | input | 1 | 1: length and continuation are taken at the response start |
| pid | input | 8 | Protected identifier used as the enhanced-mode seed |
| hdr_start | input | 1 | Header-start event pulse |
| rsp_start | input | 1 | Response or group start pulse |
| tx_valid | output | 1 | A byte is offered to the serializer |
| tx_ready | input | 1 | The serializer takes the byte |
| tx_data | output | 8 | Byte offered to the serializer |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| buf_idx | output | 3 | Byte position within the current group |
| buf_rdata | input | 8 | Buffer byte at buf_idx (transmit) |
| buf_we | output | 1 | Write strobe for a received data byte |
| buf_wdata | output | 8 | Received data byte to store |
| busy | output | 1 | Not idle |
| grp_wait | output | 1 | A non-final group finished and the block waits for the next start |
| done | output | 1 | One-cycle pulse at the end of the frame |
| cks_err | output | 1 | One-cycle pulse when the received checksum is wrong |
| cfg_err | output | 1 | One-cycle pulse when a start is refused for a bad length |

## Verification
Two outcomes of the checksum byte land in the same cycle: the end-of-frame pulse and the checksum-error pulse. The bench sends receive frames that carry a deliberately wrong checksum byte, and correct ones as well. In the cycle after the checksum byte it requires done together with cks_err for the bad frames, and done alone for the good ones. It also sends a start pulse and a header pulse in the middle of a receive group, and judges by the buffer positions and the timing of done that neither pulse changed the frame.

// File: rtl/lin_rsp_pkg.sv
package lin_rsp_pkg;
  localparam int LEN_W = 4;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_DATA = 3'd1,
    S_CKS  = 3'd2,
    S_GRP  = 3'd3,
    S_DONE = 3'd4
  } seq_st_t;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             more;
    logic             enh;
    logic             tx;
    logic             sep;
  } grp_cfg_t;

  // 8-bit add with end-around carry
  function automatic logic [7:0] eac_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction
endpackage

// File: rtl/lin_cks_acc.sv
module lin_cks_acc
  import lin_rsp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       seed_en,
  input  logic [7:0] seed_val,
  input  logic       add_en,
  input  logic [7:0] add_val,
  output logic [7:0] sum
);
  logic [7:0] sum_q, sum_d;

  always_comb begin
    sum_d = sum_q;
    if (seed_en)     sum_d = seed_val;
    else if (add_en) sum_d = eac_add(sum_q, add_val);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                  sum_q <= 8'd0;
    else if (seed_en || add_en)   sum_q <= sum_d;
  end

  assign sum = sum_q;

  p_seed_add_excl_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    !(seed_en && add_en));
endmodule

// File: rtl/lin_byte_ctr.sv
module lin_byte_ctr #(
  parameter int MAX_LEN = 8,
  localparam int CW = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr || inc)  cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= CW'(MAX_LEN));
endmodule

// File: rtl/lin_cfg_hold.sv
module lin_cfg_hold
  import lin_rsp_pkg::*;
#(
  parameter int MAX_LEN = 8
) (
  input  logic     clk,
  input  logic     rst_ni,
  input  grp_cfg_t live,
  input  logic     hdr_start,
  input  logic     in_idle,
  input  logic     accept,
  output grp_cfg_t cand,
  output logic     cand_ok,
  output grp_cfg_t act
);
  grp_cfg_t snap_q, act_q;
  logic     snap_en;

  assign snap_en = hdr_start && in_idle;

  always_comb begin
    cand = live;
    if (in_idle) begin
      cand.tx  = snap_q.tx;
      cand.enh = snap_q.enh;
      cand.sep = snap_q.sep;
      if (!snap_q.sep) begin
        cand.len  = snap_q.len;
        cand.more = snap_q.more;
      end
    end else begin
      cand.tx  = act_q.tx;
      cand.enh = act_q.enh;
      cand.sep = act_q.sep;
    end
    cand_ok = (cand.len <= LEN_W'(MAX_LEN));
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      snap_q <= '0;
    else if (snap_en) snap_q <= live;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     act_q <= '0;
    else if (accept) act_q <= cand;
  end

  assign act = act_q;

  p_act_legal_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    accept |=> act_q.len <= LEN_W'(MAX_LEN));
endmodule

// File: rtl/lin_resp_seq.sv
module lin_resp_seq
  import lin_rsp_pkg::*;
#(
  parameter int MAX_LEN = 8,
  localparam int IDX_W = $clog2(MAX_LEN),
  localparam int CW    = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_more,
  input  logic             cfg_enh,
  input  logic             cfg_tx,
  input  logic             cfg_sep,
  input  logic [7:0]       pid,
  input  logic             hdr_start,
  input  logic             rsp_start,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic [IDX_W-1:0] buf_idx,
  input  logic [7:0]       buf_rdata,
  output logic             buf_we,
  output logic [7:0]       buf_wdata,
  output logic             busy,
  output logic             grp_wait,
  output logic             done,
  output logic             cks_err,
  output logic             cfg_err
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  seq_st_t   st_q, st_d;
  grp_cfg_t  live, cand, act;
  logic      cand_ok, accept, refuse, in_idle, in_xfer;
  logic      fire, last, seed_en, add_en, cks_bad;
  logic      cks_err_q, cfg_err_q;
  logic [7:0] sum, byte_in;
  logic [CW-1:0] cnt;

  assign live = '{len: cfg_len, more: cfg_more, enh: cfg_enh, tx: cfg_tx, sep: cfg_sep};
  assign in_idle = (st_q == S_IDLE);
  assign in_xfer = (st_q == S_DATA) || (st_q == S_CKS);

  lin_cfg_hold #(.MAX_LEN(MAX_LEN)) u_cfg (
    .clk(clk), .rst_ni(rst_i), .live(live), .hdr_start(hdr_start),
    .in_idle(in_idle), .accept(accept), .cand(cand), .cand_ok(cand_ok), .act(act)
  );

  // byte handshake in either direction
  assign tx_valid = act.tx && in_xfer;
  assign fire     = act.tx ? (tx_valid && tx_ready) : (!act.tx && in_xfer && rx_valid);
  assign byte_in  = act.tx ? buf_rdata : rx_data;
  assign last     = (cnt + 1'b1) == CW'(act.len);

  always_comb begin
    st_d   = st_q;
    accept = 1'b0;
    refuse = 1'b0;
    case (st_q)
      S_IDLE, S_GRP: begin
        if (rsp_start) begin
          if (!cand_ok) refuse = 1'b1;
          else begin
            accept = 1'b1;
            if (cand.len != '0) st_d = S_DATA;
            else if (cand.more) st_d = S_GRP;
            else                st_d = S_CKS;
          end
        end
      end
      S_DATA:  if (fire && last) st_d = act.more ? S_GRP : S_CKS;
      S_CKS:   if (fire) st_d = S_DONE;
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  assign seed_en = accept && in_idle;
  assign add_en  = fire && (st_q == S_DATA);
  assign cks_bad = (st_q == S_CKS) && fire && !act.tx && (eac_add(sum, rx_data) != 8'hFF);

  lin_cks_acc u_acc (
    .clk(clk), .rst_ni(rst_i), .seed_en(seed_en),
    .seed_val(cand.enh ? pid : 8'h00), .add_en(add_en), .add_val(byte_in), .sum(sum)
  );

  lin_byte_ctr #(.MAX_LEN(MAX_LEN)) u_ctr (
    .clk(clk), .rst_ni(rst_i), .clr(accept), .inc(add_en), .cnt(cnt)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q      <= S_IDLE;
      cks_err_q <= 1'b0;
      cfg_err_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      cks_err_q <= cks_bad;
      cfg_err_q <= refuse;
    end
  end

  assign tx_data   = (st_q == S_CKS) ? ~sum : buf_rdata;
  assign buf_idx   = cnt[IDX_W-1:0];
  assign buf_we    = add_en && !act.tx;
  assign buf_wdata = rx_data;
  assign busy      = !in_idle;
  assign grp_wait  = (st_q == S_GRP);
  assign done      = (st_q == S_DONE);
  assign cks_err   = cks_err_q;
  assign cfg_err   = cfg_err_q;

  p_refuse_hold_r2: assert property (@(posedge clk) disable iff (!rst_i)
    cfg_err |-> st_q == $past(st_q));
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(buf_idx) && $stable(st_q));
  p_no_write_tx_r4: assert property (@(posedge clk) disable iff (!rst_i)
    buf_we |-> !tx_valid);
  p_err_with_done_r4: assert property (@(posedge clk) disable iff (!rst_i)
    cks_err |-> done);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_i)
    done |=> !done && !busy);
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_i)
    ($past(st_q) == S_DATA && !$past(fire)) |-> st_q == S_DATA);
endmodule

// File: tb/lin_resp_seq_test.sv
module lin_resp_seq_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] cfg_len;
  logic       cfg_more, cfg_enh, cfg_tx, cfg_sep;
  logic [7:0] pid;
  logic       hdr_start, rsp_start, tx_ready, rx_valid;
  logic [7:0] rx_data;
  logic       tx_valid, buf_we, busy, grp_wait, done, cks_err, cfg_err;
  logic [7:0] tx_data, buf_wdata, buf_rdata;
  logic [2:0] buf_idx;
  logic [7:0] mem [8];

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;
  assign buf_rdata = mem[buf_idx];

  lin_resp_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_more(cfg_more), .cfg_enh(cfg_enh),
    .cfg_tx(cfg_tx), .cfg_sep(cfg_sep), .pid(pid), .hdr_start(hdr_start), .rsp_start(rsp_start),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .buf_idx(buf_idx), .buf_rdata(buf_rdata), .buf_we(buf_we),
    .buf_wdata(buf_wdata), .busy(busy), .grp_wait(grp_wait), .done(done),
    .cks_err(cks_err), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference: end-around-carry sum of a plain integer total
  function automatic int eac(input int s);
    return (s == 0) ? 0 : ((s - 1) % 255) + 1;
  endfunction

  task automatic setcfg(input int len, input bit more, input bit enh, input bit tx, input bit sep);
    cfg_len = 4'(len); cfg_more = more; cfg_enh = enh; cfg_tx = tx; cfg_sep = sep;
  endtask

  task automatic pulse_hdr;
    hdr_start = 1'b1; @(negedge clk); hdr_start = 1'b0;
  endtask

  task automatic pulse_rsp;
    rsp_start = 1'b1; @(negedge clk); rsp_start = 1'b0;
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 8; i++) mem[i] = 8'((i * 37 + seed * 11 + 5) & 8'hFF);
  endtask

  // transmit one group; stall inserts idle ready cycles
  task automatic tx_group(input int n, input bit more, input bit stall, inout int run);
    int got = 0; int guard = 0; bit seen_cks = 0; int exp_cks;
    while (!(more ? (got == n) : seen_cks) && guard < 200) begin
      tx_ready = stall ? guard[0] : 1'b1;
      #1;
      if (tx_valid && tx_ready) begin
        if (got < n) begin
          check(tx_data == mem[got] && buf_idx == 3'(got), "R3 tx byte", tx_data, mem[got]);
          run += mem[got]; got++;
        end else begin
          exp_cks = 8'hFF ^ eac(run);
          check(tx_data == 8'(exp_cks), "R6 tx checksum", tx_data, exp_cks);
          seen_cks = 1;
        end
      end
      guard++;
      @(negedge clk);
    end
    tx_ready = 1'b0;
    check(guard < 200, "R3 tx progress", guard, 0);
    if (more) check(grp_wait && !done && !tx_valid, "R8 group wait", grp_wait, 1);
    else begin
      check(done && !cks_err, "R11 done pulse", done, 1);
      @(negedge clk);
      check(!done && !busy, "R11 idle after done", busy, 0);
    end
  endtask

  // receive one group; corrupt flips the checksum; poke sends stray starts mid-group
  task automatic rx_group(input int n, input bit more, input bit corrupt, input bit poke,
                          inout int run);
    int cb;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_data = 8'((i * 53 + run + 9) & 8'hFF);
      if (poke && i == 2) begin rsp_start = 1'b1; hdr_start = 1'b1; end
      #1;
      check(buf_we && buf_idx == 3'(i) && buf_wdata == rx_data, "R4 rx store", buf_idx, i);
      run += rx_data;
      @(negedge clk);
      rsp_start = 1'b0; hdr_start = 1'b0;
    end
    if (more) begin
      rx_valid = 1'b0;
      #1;
      check(grp_wait && !buf_we, "R8 rx group wait", grp_wait, 1);
      @(negedge clk);
    end else begin
      cb = (8'hFF ^ eac(run)) & 8'hFF;
      rx_valid = 1'b1; rx_data = corrupt ? 8'(cb ^ 8'h10) : 8'(cb);
      #1;
      check(!buf_we, "R7 checksum not stored", buf_we, 0);
      @(negedge clk);
      rx_valid = 1'b0;
      check(done == 1'b1, "R11 rx done", done, 1);
      check(cks_err == corrupt, "R4 checksum error with done", cks_err, corrupt);
      @(negedge clk);
      check(!busy && !cks_err, "R11 rx idle", busy, 0);
    end
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int run;
    rst_n = 1'b0; hdr_start = 0; rsp_start = 0; tx_ready = 0; rx_valid = 0; rx_data = 0;
    pid = 8'hC3; setcfg(0, 0, 0, 0, 0); fill(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !grp_wait && !done && !cks_err && !cfg_err && !tx_valid && !buf_we,
          "R1 reset state", busy, 0);

    // sweep: every legal length, both directions, both checksum modes
    for (int tx = 0; tx < 2; tx++)
      for (int enh = 0; enh < 2; enh++)
        for (int len = 0; len <= 8; len++) begin
          pid = 8'(8'h3F + len * 29);
          fill(len + enh * 3);
          setcfg(len, 0, enh[0], tx[0], 0);
          pulse_hdr();
          run = enh ? int'(pid) : 0;   // R5 seed
          rsp_start = 1'b1;
          @(negedge clk); rsp_start = 1'b0;
          if (tx) tx_group(len, 0, len[0], run);   // R7 when len is 0
          else    rx_group(len, 0, (len % 3) == 1, 0, run);
        end

    // R2: illegal length codes are refused
    for (int code = 9; code < 16; code++) begin
      setcfg(code, 0, 0, 1, 0);
      pulse_hdr();
      rsp_start = 1'b1; @(negedge clk); rsp_start = 1'b0;
      check(cfg_err && !busy && !tx_valid, "R2 bad length refused", cfg_err, 1);
      @(negedge clk);
      check(!cfg_err && !busy, "R2 error is one cycle", cfg_err, 0);
    end

    // R9: length fixed at header when frame-separate is off
    fill(21);
    setcfg(3, 0, 0, 1, 0); pulse_hdr();
    setcfg(6, 0, 1, 0, 1);
    run = 0; pulse_rsp(); tx_group(3, 0, 0, run);
    // R9: length taken at response start when frame-separate is on
    setcfg(2, 0, 1, 1, 1); pulse_hdr();
    setcfg(5, 0, 0, 0, 0);
    run = int'(pid); pulse_rsp(); tx_group(5, 0, 1, run);

    // R8: chained transmit groups 8 + 0 + 4, enhanced
    pid = 8'h5A; fill(2);
    setcfg(8, 1, 1, 1, 0); pulse_hdr();
    run = int'(pid); pulse_rsp(); tx_group(8, 1, 0, run);
    setcfg(0, 1, 0, 0, 0); pulse_rsp();
    @(negedge clk);
    check(grp_wait && !tx_valid, "R8 empty middle group", grp_wait, 1);
    fill(7); setcfg(4, 0, 0, 0, 0); pulse_rsp(); tx_group(4, 0, 1, run);

    // R8: chained receive groups 8 + 8 + 3, classic, with an illegal reload in between
    setcfg(8, 1, 0, 0, 0); pulse_hdr();
    run = 0; pulse_rsp(); rx_group(8, 1, 0, 0, run);
    setcfg(12, 0, 0, 0, 0);
    rsp_start = 1'b1; @(negedge clk); rsp_start = 1'b0;
    check(cfg_err && grp_wait, "R2 refused reload keeps group wait", grp_wait, 1);
    setcfg(8, 1, 0, 0, 0); pulse_rsp(); rx_group(8, 1, 0, 0, run);
    setcfg(3, 0, 0, 0, 0); pulse_rsp(); rx_group(3, 0, 1, 0, run);

    // R10: stray start pulses in the middle of a receive group change nothing
    setcfg(6, 0, 1, 0, 0); pid = 8'h11; pulse_hdr();
    setcfg(1, 0, 0, 1, 0);
    run = int'(pid); pulse_rsp(); rx_group(6, 0, 0, 1, run);
    // R10: the stray header pulse did not replace the snapshot (receive, enhanced, 6)
    run = int'(pid); pulse_rsp(); rx_group(6, 0, 0, 0, run);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule